// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the integer arithmetic and logic core of an address-generation datapath. It combines two 32-bit operands under a 4-bit opcode and an unsigned-mode bit in a single combinational pass. It returns the result and a result-write strobe, and it derives zero, negative, overflow and carry flags from the operation.

The flags go into a status register on the clock edge, but only when the caller asserts the flag-write enable. A condition evaluator reads that registered status word and answers whether a selected condition holds. The operation that sets the flags and the test that consumes them therefore sit in consecutive cycles. The evaluator offers equal, less-than and less-or-equal, the negation of each, and a signed or unsigned reading of the ordering tests.

Top module: `ialu_core`

## Requirements
- R1: ADD (opcode 0) returns a+b mod 2^32 with carry = carry out of bit 31. SUB (opcode 1) returns a-b with carry = 1 exactly when a >= b unsigned (no borrow). For both, overflow is signed two's-complement overflow, and zero and negative come from the result.
- R2: CMP (opcode 2) sets the flags exactly as SUB would and holds res_wr low. Every defined opcode other than CMP drives res_wr high.
- R3: ASR (opcode 3) and LSR (opcode 4) shift op_a right only, arithmetically and logically, by op_b[4:0]. They clear overflow and carry.
- R4: ROT (opcode 5) rotates op_a left by op_b[4:0]. A negative op_b such as -k therefore rotates right by k. Overflow and carry are cleared.
- R5: AND (6) gives a&b, ANDN (7) gives a&~b, NOT (8) gives ~a, OR (9) gives a|b and XOR (10) gives a^b. Each clears overflow and carry and sets zero and negative from the result.
- R6: ABS (opcode 11) returns |a|. For a = 0x80000000 it returns 0x80000000 with overflow set, otherwise with overflow clear. Carry is cleared.
- R7: MIN (opcode 12) and MAX (opcode 13) return the smaller and larger operand. The comparison is signed when uns is 0 and unsigned when uns is 1. Overflow and carry are cleared.
- R8: flags = {zero, negative, overflow, carry} on bits 3..0. Synchronous reset clears them. They load on a rising edge only when flag_we is high, and hold otherwise.
- R9: cond_true evaluates the registered flags for cond_sel: EQ=0 gives Z, LT=1, LE=2 gives LT|Z, NEQ=3, NLT=4 and NLE=5 are the negations, and codes 6 and 7 give 0. LT is N^V when cond_uns=0 and !C when cond_uns=1.
- R10: Opcodes 14 and 15 are undefined. They return result 0 with res_wr low and leave the flags unchanged even with flag_we high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand / shift amount |
| opcode | input | 4 | Operation select |
| uns | input | 1 | Unsigned mode for MIN/MAX |
| flag_we | input | 1 | Load status flags on this edge |
| cond_sel | input | 3 | Condition code to evaluate |
| cond_uns | input | 1 | Unsigned reading of LT/LE family |
| result | output | 32 | Operation result |
| res_wr | output | 1 | Result should be written back |
| flags | output | 4 | Registered {Z,N,V,C} |
| cond_true | output | 1 | Selected condition holds |

## Verification
The assertions check several invariants on every cycle:
- the flags hold whenever the enable is low;
- the zero flag tracks the previous result;
- logic operations leave overflow and carry cleared;
- compare and the undefined opcodes never request a write;
- an absolute value is non-negative except at the most negative input;
- a nonzero logical shift clears the top bit.

Exact arithmetic values can only be shown by the bench's sweeps. These cover carry and borrow at the wrap points, signed overflow, rotate direction for negative amounts, and the signed/unsigned split of MIN/MAX. They also cover every condition under both orderings.

// File: rtl/ialu_pkg.sv
package ialu_pkg;

    localparam int IALU_W = 32;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_CMP  = 4'd2,
        OP_ASR  = 4'd3,
        OP_LSR  = 4'd4,
        OP_ROT  = 4'd5,
        OP_AND  = 4'd6,
        OP_ANDN = 4'd7,
        OP_NOT  = 4'd8,
        OP_OR   = 4'd9,
        OP_XOR  = 4'd10,
        OP_ABS  = 4'd11,
        OP_MIN  = 4'd12,
        OP_MAX  = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } ialu_op_e;

    typedef enum logic [2:0] {
        CND_EQ   = 3'd0,
        CND_LT   = 3'd1,
        CND_LE   = 3'd2,
        CND_NEQ  = 3'd3,
        CND_NLT  = 3'd4,
        CND_NLE  = 3'd5,
        CND_RSV0 = 3'd6,
        CND_RSV1 = 3'd7
    } ialu_cond_e;

    typedef struct packed {
        logic z;
        logic n;
        logic v;
        logic c;
    } ialu_flags_t;

    typedef enum logic [1:0] {
        UNIT_ARITH = 2'd0,
        UNIT_SHIFT = 2'd1,
        UNIT_LOGIC = 2'd2,
        UNIT_NONE  = 2'd3
    } ialu_unit_e;

    function automatic ialu_unit_e unit_of(ialu_op_e op);
        case (op)
            OP_ADD, OP_SUB, OP_CMP, OP_ABS, OP_MIN, OP_MAX: return UNIT_ARITH;
            OP_ASR, OP_LSR, OP_ROT:                         return UNIT_SHIFT;
            OP_AND, OP_ANDN, OP_NOT, OP_OR, OP_XOR:         return UNIT_LOGIC;
            default:                                        return UNIT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ialu_arith.sv
module ialu_arith
    import ialu_pkg::*;
#(
    parameter int W = IALU_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  ialu_op_e     op,
    input  logic         uns,
    output logic [W-1:0] res,
    output logic         v,
    output logic         c
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic [W:0] sum;
    logic [W:0] diff;
    logic       a_lt_b;

    always_comb begin
        sum    = {1'b0, a} + {1'b0, b};
        diff   = {1'b0, a} + {1'b0, ~b} + (W+1)'(1);
        a_lt_b = uns ? (a < b) : ($signed(a) < $signed(b));
        res    = '0;
        v      = 1'b0;
        c      = 1'b0;
        case (op)
            OP_ADD: begin
                res = sum[W-1:0];
                c   = sum[W];
                v   = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
            end
            OP_SUB, OP_CMP: begin
                res = diff[W-1:0];
                c   = diff[W];
                v   = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);
            end
            OP_ABS: begin
                res = a[W-1] ? (~a + W'(1)) : a;
                v   = (a == MOST_NEG);
            end
            OP_MIN: res = a_lt_b ? a : b;
            OP_MAX: res = a_lt_b ? b : a;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/ialu_shift.sv
module ialu_shift
    import ialu_pkg::*;
#(
    parameter int W   = IALU_W,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   a,
    input  logic [SHW-1:0] amt,
    input  ialu_op_e       op,
    output logic [W-1:0]   res
);
    logic [2*W-1:0] dbl;

    always_comb begin
        dbl = {a, a} << amt;
        case (op)
            OP_ASR:  res = W'($signed(a) >>> amt);
            OP_LSR:  res = a >> amt;
            OP_ROT:  res = dbl[2*W-1:W];
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/ialu_logic.sv
module ialu_logic
    import ialu_pkg::*;
#(
    parameter int W = IALU_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  ialu_op_e     op,
    output logic [W-1:0] res
);
    always_comb begin
        case (op)
            OP_AND:  res = a & b;
            OP_ANDN: res = a & ~b;
            OP_NOT:  res = ~a;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/ialu_cond.sv
module ialu_cond
    import ialu_pkg::*;
(
    input  ialu_flags_t st,
    input  ialu_cond_e  sel,
    input  logic        uns,
    output logic        hit
);
    logic lt;
    logic le;

    always_comb begin
        lt = uns ? ~st.c : (st.n ^ st.v);
        le = lt | st.z;
        case (sel)
            CND_EQ:  hit = st.z;
            CND_LT:  hit = lt;
            CND_LE:  hit = le;
            CND_NEQ: hit = ~st.z;
            CND_NLT: hit = ~lt;
            CND_NLE: hit = ~le;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/ialu_core.sv
module ialu_core
    import ialu_pkg::*;
#(
    parameter int W   = IALU_W,
    parameter int SHW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [3:0]   opcode,
    input  logic         uns,
    input  logic         flag_we,
    input  logic [2:0]   cond_sel,
    input  logic         cond_uns,
    output logic [W-1:0] result,
    output logic         res_wr,
    output logic [3:0]   flags,
    output logic         cond_true
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    ialu_op_e    op;
    ialu_unit_e  unit;
    logic [W-1:0] r_arith, r_shift, r_logic;
    logic         v_arith, c_arith;
    ialu_flags_t  nxt, st_q;

    assign op   = ialu_op_e'(opcode);
    assign unit = unit_of(op);

    ialu_arith #(.W(W)) u_arith (
        .a(op_a), .b(op_b), .op(op), .uns(uns),
        .res(r_arith), .v(v_arith), .c(c_arith)
    );

    ialu_shift #(.W(W), .SHW(SHW)) u_shift (
        .a(op_a), .amt(op_b[SHW-1:0]), .op(op), .res(r_shift)
    );

    ialu_logic #(.W(W)) u_logic (
        .a(op_a), .b(op_b), .op(op), .res(r_logic)
    );

    always_comb begin
        case (unit)
            UNIT_ARITH: result = r_arith;
            UNIT_SHIFT: result = r_shift;
            UNIT_LOGIC: result = r_logic;
            default:    result = '0;
        endcase
        res_wr = (unit != UNIT_NONE) && (op != OP_CMP);
        nxt.z  = (result == '0);
        nxt.n  = result[W-1];
        nxt.v  = (unit == UNIT_ARITH) ? v_arith : 1'b0;
        nxt.c  = (unit == UNIT_ARITH) ? c_arith : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else if (flag_we && unit != UNIT_NONE)
            st_q <= nxt;
    end

    assign flags = st_q;

    ialu_cond u_cond (
        .st(st_q), .sel(ialu_cond_e'(cond_sel)), .uns(cond_uns), .hit(cond_true)
    );

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> $stable(flags)); // R8

    AST_ZERO_TRACK: assert property (@(posedge clk) disable iff (rst)
        (flag_we && opcode < 4'd14) |=> (flags[3] == ($past(result) == '0))); // R8

    AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (opcode >= 4'd14) |-> (!res_wr && result == '0)); // R10

    AST_UNDEF_KEEP: assert property (@(posedge clk) disable iff (rst)
        (opcode >= 4'd14) |=> $stable(flags)); // R10

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (opcode == 4'd2) |-> !res_wr); // R2

    AST_LOGIC_CLEAR_VC: assert property (@(posedge clk) disable iff (rst)
        (flag_we && opcode >= 4'd6 && opcode <= 4'd10) |=> (flags[1:0] == 2'b00)); // R5

    AST_ABS_SIGN: assert property (@(posedge clk) disable iff (rst)
        (opcode == 4'd11 && op_a != MOST_NEG) |-> !result[W-1]); // R6

    AST_LSR_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (opcode == 4'd4 && op_b[SHW-1:0] != '0) |-> !result[W-1]); // R3

endmodule

// File: tb/sim_ialu_core.sv
`timescale 1ns/100ps
module sim_ialu_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_a = '0, op_b = '0;
    logic [3:0]  opcode = '0;
    logic        uns = 1'b0, flag_we = 1'b0, cond_uns = 1'b0;
    logic [2:0]  cond_sel = '0;
    logic [31:0] result;
    logic        res_wr;
    logic [3:0]  flags;
    logic        cond_true;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ialu_core u0 (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .opcode(opcode),
        .uns(uns), .flag_we(flag_we), .cond_sel(cond_sel), .cond_uns(cond_uns),
        .result(result), .res_wr(res_wr), .flags(flags), .cond_true(cond_true)
    );

    logic [31:0] vals [10] = '{32'h0, 32'h1, 32'h2, 32'h7FFF_FFFF, 32'h8000_0000,
                              32'hFFFF_FFFF, 32'h0000_001F, 32'hFFFF_FFFC,
                              32'h1234_5678, 32'hA5A5_0F0F};

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (op=%0d a=%h b=%h uns=%0b)",
                     req, act, exp, opcode, op_a, op_b, uns);
        end
    endtask

    function automatic string req_of(int o);
        case (o)
            0, 1: return "R1";
            2: return "R2";
            3, 4: return "R3";
            5: return "R4";
            6, 7, 8, 9, 10: return "R5";
            11: return "R6";
            12, 13: return "R7";
            default: return "R10";
        endcase
    endfunction

    // returns {wr, flags[3:0], result[31:0]}
    function automatic logic [36:0] model(int o, logic [31:0] a, logic [31:0] b,
                                          logic u, logic [3:0] prev);
        logic [63:0] t;
        logic [31:0] r;
        logic v, c, wr, lt;
        int k;
        v = 0; c = 0; wr = 1; r = 0;
        k = int'(b[4:0]);
        case (o)
            0: begin t = 64'(a) + 64'(b); r = t[31:0]; c = t[32];
                     v = (a[31] == b[31]) && (r[31] != a[31]); end
            1, 2: begin r = a - b; c = (a >= b);
                     v = (a[31] != b[31]) && (r[31] != a[31]); wr = (o == 1); end
            3: r = 32'($signed(a) >>> k);
            4: r = a >> k;
            5: begin t = {a, a}; r = (k == 0) ? a : 32'((t << k) >> 32); end
            6: r = a & b;
            7: r = a & ~b;
            8: r = ~a;
            9: r = a | b;
            10: r = a ^ b;
            11: begin r = a[31] ? (32'd0 - a) : a; v = (a == 32'h8000_0000); end
            12, 13: begin
                lt = u ? (a < b) : ($signed(a) < $signed(b));
                r = ((o == 12) == lt) ? a : b;
            end
            default: begin
                return {1'b0, prev, 32'h0};
            end
        endcase
        return {wr, (r == 0), r[31], v, c, r};
    endfunction

    function automatic logic cond_model(int s, logic [3:0] f, logic cu);
        logic lt, le;
        lt = cu ? !f[0] : (f[2] ^ f[1]);
        le = lt | f[3];
        case (s)
            0: return f[3];
            1: return lt;
            2: return le;
            3: return !f[3];
            4: return !lt;
            5: return !le;
            default: return 1'b0;
        endcase
    endfunction

    logic [3:0] exp_flags = '0;

    task automatic run_op(int o, logic [31:0] a, logic [31:0] b, logic u, logic we);
        logic [36:0] m;
        @(negedge clk);
        op_a = a; op_b = b; opcode = 4'(o); uns = u; flag_we = we;
        m = model(o, a, b, u, exp_flags);
        #1;
        check(result == m[31:0], req_of(o), result, m[31:0]);
        check(res_wr == m[36], (o == 2) ? "R2" : "R2 write strobe", 32'(res_wr), 32'(m[36]));
        if (we) exp_flags = m[35:32];
        @(posedge clk);
        #1;
        flag_we = 1'b0;
        check(flags == exp_flags, we ? req_of(o) : "R8 hold", 32'(flags), 32'(exp_flags));
        for (int s = 0; s < 8; s++) begin
            for (int cu = 0; cu < 2; cu++) begin
                cond_sel = 3'(s); cond_uns = 1'(cu);
                #0.1;
                check(cond_true == cond_model(s, exp_flags, 1'(cu)), "R9",
                      32'(cond_true), 32'(cond_model(s, exp_flags, 1'(cu))));
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R8: reset state, and reset overrides a flag write
        opcode = 4'd0; op_a = 32'hFFFF_FFFF; op_b = 32'h1; flag_we = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0; flag_we = 1'b0;
        #1;
        check(flags == 4'h0, "R8 reset", 32'(flags), 32'h0);
        cond_sel = 3'd0; cond_uns = 1'b0;
        #0.1;
        check(cond_true == 1'b0, "R9 reset EQ", 32'(cond_true), 32'h0);

        for (int u = 0; u < 2; u++)
            for (int o = 0; o < 16; o++)
                for (int i = 0; i < 10; i++)
                    for (int j = 0; j < 10; j++)
                        run_op(o, vals[i], vals[j], 1'(u), 1'b1);

        // R8: flags held when write enable is low
        run_op(0, 32'h0, 32'h0, 1'b0, 1'b1);
        run_op(0, 32'hFFFF_FFFF, 32'h2, 1'b0, 1'b0);
        // R10: undefined opcode after a nonzero flag state
        run_op(1, 32'h1, 32'h2, 1'b0, 1'b1);
        run_op(14, 32'h5, 32'h5, 1'b0, 1'b1);
        run_op(15, 32'h0, 32'h0, 1'b1, 1'b1);
        // R4: negative rotate amount rotates right
        run_op(5, 32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 1'b1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule